// File: doc/BRIEF.md
# Convolution Tap Sharing Analyzer

This unit examines a programmable 3x3 convolution mask when it is configured and works out how much multiplier sharing the mask allows. Software or a configuration sequencer writes the nine signed coefficients into a small bank, one position per write, and then pulses a start strobe. The unit walks the nine positions in raster order. Each coefficient is compared against the list of distinct values found so far. A value not yet in the list is appended to it. Every position is labelled with the slot number of its value in that list.

When the walk ends, the unit publishes four results: the per-position group map, the number of distinct values, the ordered table of distinct values, and the number of output pixels that a fixed pool of multipliers can compute at once. That pool holds one multiplier per distinct tap per pixel in flight. A downstream pixel datapath uses these results to pre-add pixels that share a coefficient, so that fewer multipliers are needed for each pixel. The published results stay unchanged until the next analysis completes. A done flag tells the consumer when the results are valid.

Top module: `tap_share_analyzer`

## Requirements
- R1: While idle, a pulse on `load_en` writes `load_val` (8-bit two's complement) into mask position `load_idx` for index 0 to 8. An index of 9 to 15 changes no position.
- R2: A `start` pulse sampled while idle begins an analysis. `done` is 0 from the edge after that sample, and becomes 1 after the tenth rising edge counted from the one that sampled `start`.
- R3: Distinct values get slots in order of first appearance, scanning positions 0 to 8. The 4-bit field `group_map[4*p +: 4]` holds the slot of position p's value.
- R4: `uniq_cnt` equals the number of distinct coefficient values in the mask. A zero coefficient counts as a value like any other. For example, an all-equal mask gives 1, a -1/8 sharpening mask gives 2, a -1/0/+1 row-gradient mask gives 3, and a -1/-2/0/+1/+2 weighted-gradient mask gives 5.
- R5: `uniq_tbl[8*k +: 8]` holds the value in slot k for k below `uniq_cnt`. All slots at or above `uniq_cnt` read 0.
- R6: `par_factor` equals floor(18 / `uniq_cnt`), giving 18, 9, 6, 4, 3, 3, 2, 2, 2 for counts 1 to 9.
- R7: A `load_en` pulse while an analysis runs is ignored. It affects neither the running analysis nor the stored mask seen by later analyses.
- R8: A `start` pulse while an analysis runs is ignored. The published outputs and `done` hold their last values until the next analysis completes, even if positions are reloaded in between.
- R9: After reset, `done`, `uniq_cnt`, `par_factor`, `group_map` and `uniq_tbl` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Coefficient write strobe |
| load_idx | input | 4 | Mask position to write (0 to 8 valid) |
| load_val | input | 8 | Signed coefficient value |
| start | input | 1 | Begin analysis strobe |
| group_map | output | 36 | Slot number per position, 4 bits each, position 0 in the low bits |
| uniq_cnt | output | 4 | Number of distinct coefficient values |
| uniq_tbl | output | 72 | Distinct values by slot, 8 bits each, slot 0 in the low bits |
| par_factor | output | 5 | Output pixels computable in parallel |
| done | output | 1 | Published results are valid |

## Verification
The bench builds the block with its default multiplier pool of 18, a 3x3 mask and 8-bit coefficients. With these values, masks can be chosen that reach every count from 1 to 9 and every row of the parallelism mapping. The values include the extremes -128 and 127, and the zero coefficient. With a ten-cycle analysis, a write or a second start can be placed in the middle of a run, which exercises the lockout and hold behaviour at a known cycle.

// File: rtl/tapgrp_pkg.sv
package tapgrp_pkg;

    localparam int TAP_COUNT  = 9;
    localparam int COEF_W     = 8;
    localparam int GIDX_W     = 4;
    localparam int POS_W      = $clog2(TAP_COUNT + 1);
    localparam int CNT_W      = $clog2(TAP_COUNT + 1);
    localparam int POOL_MULTS = 18;

    typedef logic [TAP_COUNT-1:0][GIDX_W-1:0] grp_map_t;
    typedef logic [TAP_COUNT-1:0][COEF_W-1:0] val_tbl_t;

    typedef struct packed {
        grp_map_t             map;
        val_tbl_t             tbl;
        logic [CNT_W-1:0]     cnt;
    } share_res_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic int pixels_per_pass(input int uniq, input int pool);
        if (uniq <= 0) return 0;
        return pool / uniq;
    endfunction

endpackage

// File: rtl/tapgrp_coef_bank.sv
module tapgrp_coef_bank #(
    parameter int N  = 9,
    parameter int W  = 8,
    parameter int IW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [W-1:0]         wr_val,
    input  logic [IW-1:0]        rd_idx,
    output logic [W-1:0]         rd_val
);

    logic [N-1:0][W-1:0] coef_q;

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    coef_q[gi] <= '0;
                end else if (wr_en && !lock && (wr_idx == IW'(gi))) begin
                    coef_q[gi] <= wr_val;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) rd_val = coef_q[i];
        end
    end

    // R7
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (lock && wr_en) |=> $stable(coef_q));

endmodule

// File: rtl/tapgrp_matcher.sv
module tapgrp_matcher #(
    parameter int N  = 9,
    parameter int W  = 8,
    parameter int IW = 4,
    parameter int CW = 4
) (
    input  logic [W-1:0]          probe,
    input  logic [N-1:0][W-1:0]   table_q,
    input  logic [CW-1:0]         fill,
    output logic                  hit,
    output logic [IW-1:0]         hit_idx
);

    logic [N-1:0] eq;

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_cmp
            assign eq[gi] = (CW'(gi) < fill) && (table_q[gi] == probe);
        end
    endgenerate

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IW'(i);
        end
    end

endmodule

// File: rtl/tap_share_analyzer.sv
module tap_share_analyzer
    import tapgrp_pkg::*;
#(
    parameter  int MULT_POOL = POOL_MULTS,
    localparam int PAR_W     = $clog2(MULT_POOL + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_en,
    input  logic [POS_W-1:0]              load_idx,
    input  logic [COEF_W-1:0]             load_val,
    input  logic                          start,
    output logic [TAP_COUNT*GIDX_W-1:0]   group_map,
    output logic [CNT_W-1:0]              uniq_cnt,
    output logic [TAP_COUNT*COEF_W-1:0]   uniq_tbl,
    output logic [PAR_W-1:0]              par_factor,
    output logic                          done
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TAP_COUNT - 1);

    scan_state_e        state;
    logic [POS_W-1:0]   pos;
    share_res_t         work;
    share_res_t         nxt;
    share_res_t         pub;
    logic [COEF_W-1:0]  cur_coef;
    logic               m_hit;
    logic [GIDX_W-1:0]  m_idx;
    logic               busy;

    assign busy = (state == ST_SCAN);

    tapgrp_coef_bank #(
        .N  (TAP_COUNT),
        .W  (COEF_W),
        .IW (POS_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .lock   (busy),
        .wr_en  (load_en),
        .wr_idx (load_idx),
        .wr_val (load_val),
        .rd_idx (pos),
        .rd_val (cur_coef)
    );

    tapgrp_matcher #(
        .N  (TAP_COUNT),
        .W  (COEF_W),
        .IW (GIDX_W),
        .CW (CNT_W)
    ) u_match (
        .probe   (cur_coef),
        .table_q (work.tbl),
        .fill    (work.cnt),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    always_comb begin
        nxt = work;
        if (m_hit) begin
            nxt.map[pos] = m_idx;
        end else begin
            nxt.tbl[work.cnt] = cur_coef;
            nxt.map[pos]      = GIDX_W'(work.cnt);
            nxt.cnt           = work.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pos   <= '0;
            work  <= '0;
            pub   <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SCAN;
                        pos   <= '0;
                        work  <= '0;
                        done  <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    work <= nxt;
                    if (pos == LAST_POS) begin
                        pub   <= nxt;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign group_map  = pub.map;
    assign uniq_tbl   = pub.tbl;
    assign uniq_cnt   = pub.cnt;
    assign par_factor = PAR_W'(pixels_per_pass(int'(pub.cnt), MULT_POOL));

    // R2
    busy_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R8
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pub));

    // R3
    match_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && m_hit) |-> (CNT_W'(m_idx) < work.cnt));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (uniq_cnt >= CNT_W'(1) && uniq_cnt <= CNT_W'(TAP_COUNT)));

    // R6
    pool_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(par_factor) * int'(uniq_cnt) <= MULT_POOL));

endmodule

// File: tb/sim_tap_share_analyzer.sv
module sim_tap_share_analyzer;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [3:0]  load_idx;
    logic [7:0]  load_val;
    logic        start;
    logic [35:0] group_map;
    logic [3:0]  uniq_cnt;
    logic [71:0] uniq_tbl;
    logic [4:0]  par_factor;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          cur[9];
    logic [35:0] exp_map;
    logic [71:0] exp_tbl;
    int          exp_cnt;

    always #2 clk = ~clk;

    tap_share_analyzer u0 (
        .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
        .load_val(load_val), .start(start), .group_map(group_map),
        .uniq_cnt(uniq_cnt), .uniq_tbl(uniq_tbl), .par_factor(par_factor),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model();
        int vals[9];
        int n;
        n = 0;
        exp_map = '0;
        exp_tbl = '0;
        for (int p = 0; p < 9; p++) begin
            int g;
            g = -1;
            for (int j = 0; j < n; j++) begin
                if (g < 0 && vals[j] == cur[p]) g = j;
            end
            if (g < 0) begin
                vals[n] = cur[p];
                exp_tbl[8*n +: 8] = 8'(cur[p]);
                g = n;
                n++;
            end
            exp_map[4*p +: 4] = 4'(g);
        end
        exp_cnt = n;
    endtask

    task automatic load_mask();
        for (int p = 0; p < 9; p++) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_idx = 4'(p);
            load_val = 8'(cur[p]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic check_outputs(input string req);
        chk(group_map == exp_map, "R3", {req, " group map"}, 72'(group_map), 72'(exp_map));
        chk(int'(uniq_cnt) == exp_cnt, "R4", {req, " unique count"}, 72'(uniq_cnt), 72'(exp_cnt));
        chk(uniq_tbl == exp_tbl, "R5", {req, " unique table"}, uniq_tbl, exp_tbl);
        chk(int'(par_factor) == 18 / exp_cnt, "R6", {req, " parallel factor"},
            72'(par_factor), 72'(18 / exp_cnt));
    endtask

    // mode 0: plain, 1: second start mid-run, 2: write mid-run
    task automatic run(input string req, input int mode);
        int k;
        model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        chk(done == 1'b0, "R2", {req, " done cleared after start"}, 72'(done), 72'(0));
        while (!done && k < 40) begin
            start   = (mode == 1 && k == 3);
            load_en = (mode == 2 && k == 2);
            if (mode == 2 && k == 2) begin
                load_idx = 4'd0;
                load_val = 8'd99;
            end
            @(negedge clk);
            k++;
        end
        start   = 1'b0;
        load_en = 1'b0;
        chk(k == 10, "R2", {req, " done latency"}, 72'(k), 72'(10));
        check_outputs(req);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R9", "reset done", 72'(done), 72'(0));
        chk(uniq_cnt == 4'd0, "R9", "reset count", 72'(uniq_cnt), 72'(0));
        chk(par_factor == 5'd0, "R9", "reset parallel", 72'(par_factor), 72'(0));
        chk(group_map == '0 && uniq_tbl == '0, "R9", "reset map/table",
            72'(group_map) ^ uniq_tbl, 72'(0));
    endtask

    task automatic t_uniform();
        cur = '{3, 3, 3, 3, 3, 3, 3, 3, 3};
        load_mask();
        run("R4 uniform", 0);
    endtask

    task automatic t_sharpen();
        cur = '{-1, -1, -1, -1, 8, -1, -1, -1, -1};
        load_mask();
        run("R4 sharpen", 0);
    endtask

    task automatic t_rowgrad();
        cur = '{-1, -1, -1, 0, 0, 0, 1, 1, 1};
        load_mask();
        run("R4 row gradient", 0);
    endtask

    task automatic t_weighted();
        cur = '{-1, -2, -1, 0, 0, 0, 1, 2, 1};
        load_mask();
        run("R4 weighted gradient", 0);
    endtask

    task automatic t_four();
        cur = '{1, 2, 3, 4, 1, 2, 3, 4, 1};
        load_mask();
        run("R6 four values", 0);
    endtask

    task automatic t_zero_six();
        cur = '{0, 5, -5, 6, -6, 7, 0, 5, 0};
        load_mask();
        run("R4 zero counted six", 0);
    endtask

    task automatic t_seven();
        cur = '{1, 2, 3, 4, 5, 6, 7, 1, 2};
        load_mask();
        run("R6 seven values", 0);
    endtask

    task automatic t_all_distinct();
        cur = '{-128, 127, 1, 2, 3, 4, 5, 6, 7};
        load_mask();
        run("R5 nine extremes", 0);
    endtask

    task automatic t_busy_load();
        cur = '{4, 4, 9, 9, 4, 9, 4, 4, 4};
        load_mask();
        run("R7 write during run", 2);
        run("R7 rerun after blocked write", 0);
    endtask

    task automatic t_busy_start();
        cur = '{2, 0, 2, 0, 2, 0, 2, 0, 2};
        load_mask();
        run("R8 start during run", 1);
    endtask

    task automatic t_hold();
        logic [35:0] old_map;
        logic [71:0] old_tbl;
        int          old_cnt;
        old_map = exp_map;
        old_tbl = exp_tbl;
        old_cnt = exp_cnt;
        cur = '{10, 20, 30, 40, 50, 60, 70, 80, 90};
        load_mask();
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R8", "done held while idle", 72'(done), 72'(1));
        chk(group_map == old_map && uniq_tbl == old_tbl && int'(uniq_cnt) == old_cnt,
            "R8", "results held after reload", uniq_tbl, old_tbl);
        run("R8 new mask after hold", 0);
    endtask

    task automatic t_bad_index();
        cur = '{-7, 1, -7, 1, 0, 1, -7, 1, -7};
        load_mask();
        for (int i = 9; i < 16; i++) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_idx = 4'(i);
            load_val = 8'd50;
        end
        @(negedge clk);
        load_en = 1'b0;
        run("R1 out-of-range index", 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        load_en  = 1'b0;
        load_idx = '0;
        load_val = '0;
        start    = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_sharpen();
        t_rowgrad();
        t_weighted();
        t_four();
        t_zero_six();
        t_seven();
        t_all_distinct();
        t_busy_load();
        t_busy_start();
        t_hold();
        t_bad_index();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule